// File: doc/BRIEF.md
# Reset Pin Glitch Filter

This block cleans up an external active-low reset pin before the reset controller acts on it. The raw pin first passes through a two-flop synchronizer. Two optional filters then follow it in series. The first is a short, fixed-length qualifier that runs in every operating mode. The second is a longer qualifier whose length software programs, and it runs only while the chip is in active mode. In low-power mode the second qualifier steps aside, and its input goes straight to the output.

Each qualifier holds its last accepted pin level. It accepts a new level only after that level has been present on every clock for the required run of cycles. A shorter pulse, or one that bounces back before the run completes, leaves the output unchanged. A disabled qualifier forwards its input unchanged. The output is an active-high reset request: it is high while the accepted pin level is low.

Top module: `rst_pin_filter`

## Requirements
- R1: While rst_n is low, and on the first cycles after it rises with the pin high, rst_req is 0, whatever the level on pin_n.
- R2: When both qualifiers are disabled, rst_req equals the inverse of pin_n as sampled two clock edges earlier. A pin change reaches the output after exactly 2 rising edges.
- R3: When lp_filt_en is 1, a new pin level is accepted only after the synchronized pin has shown it on LP_CYCLES consecutive edges. With LP_CYCLES=3 alone, the output changes 5 edges after the pin changes. A 2-cycle pulse never appears, and a 3-cycle pulse does.
- R4: When rst_filt_en is 1 and lp_mode is 0, a new level is accepted only after it has been present for filt_width+1 consecutive edges. Used alone, the output changes filt_width+3 edges after the pin changes. This holds for filt_width=0, 4 and 255.
- R5: Any return of the input to the accepted level restarts the count of R4 from zero. A 3-cycle low, a 1-cycle high and then a held low with filt_width=4 yield an output change 7 edges after the second fall.
- R6: When lp_mode is 1, the programmable qualifier is bypassed even when rst_filt_en is 1. With only that qualifier enabled, the latency is 2 edges.
- R7: The fixed qualifier operates in both modes. With both qualifiers enabled and lp_mode=1, the latency is 2+LP_CYCLES edges.
- R8: With both qualifiers enabled and lp_mode=0 they act in series, with a latency of 3+LP_CYCLES+filt_width edges (8 for LP_CYCLES=3, filt_width=2), in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| pin_n | input | 1 | Raw active-low reset pin, asynchronous |
| lp_mode | input | 1 | 1 = low-power mode, 0 = active mode |
| lp_filt_en | input | 1 | Enables the fixed-length qualifier |
| rst_filt_en | input | 1 | Enables the programmable qualifier |
| filt_width | input | WIDTH_BITS | Programmable qualifier length minus one |
| rst_req | output | 1 | Filtered reset request, active high |

## Verification
The bench builds the block with its default parameters: an 8-bit width field and a 3-cycle fixed qualifier. With these values a test can reach both ends of the width range, including the full 255 setting with its 258-cycle latency. At the same defaults, pulses one cycle shorter than and exactly equal to the fixed qualifier length can be told apart. Every latency is checked on the exact edge it falls on, one cycle before and at the change, so an off-by-one in either counter or in the series ordering shows up as a mismatch.

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int WIDTH_BITS = 8,
  parameter int LP_CYCLES  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pin_n,
  input  logic                  lp_mode,
  input  logic                  lp_filt_en,
  input  logic                  rst_filt_en,
  input  logic [WIDTH_BITS-1:0] filt_width,
  output logic                  rst_req
);
  localparam int LPW = (LP_CYCLES > 1) ? $clog2(LP_CYCLES) : 1;
  localparam logic [LPW-1:0] LP_LAST = LPW'(LP_CYCLES - 1);

  logic [1:0]            sync_q;
  logic                  pin_s;
  logic                  lp_q;
  logic [LPW-1:0]        lp_cnt;
  logic                  lp_out;
  logic                  rf_active;
  logic                  rf_q;
  logic [WIDTH_BITS-1:0] rf_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], pin_n};

  assign pin_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lp_q   <= 1'b1;
      lp_cnt <= '0;
    end else if (!lp_filt_en || pin_s == lp_q || lp_cnt == LP_LAST) begin
      lp_q   <= pin_s;
      lp_cnt <= '0;
    end else begin
      lp_cnt <= lp_cnt + LPW'(1);
    end

  assign lp_out    = lp_filt_en ? lp_q : pin_s;
  assign rf_active = rst_filt_en & ~lp_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rf_q   <= 1'b1;
      rf_cnt <= '0;
    end else if (!rf_active || lp_out == rf_q || rf_cnt == filt_width) begin
      rf_q   <= lp_out;
      rf_cnt <= '0;
    end else begin
      rf_cnt <= rf_cnt + WIDTH_BITS'(1);
    end

  assign rst_req = ~(rf_active ? rf_q : lp_out);
endmodule

// File: rtl/rst_pin_filter_chk.sv
module rst_pin_filter_chk #(
  parameter int WIDTH_BITS = 8,
  parameter int LP_CYCLES  = 3,
  parameter int LPW        = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  pin_n,
  input logic                  lp_mode,
  input logic                  lp_filt_en,
  input logic                  rst_filt_en,
  input logic [WIDTH_BITS-1:0] filt_width,
  input logic                  rst_req,
  input logic                  lp_q,
  input logic [LPW-1:0]        lp_cnt,
  input logic [WIDTH_BITS-1:0] rf_cnt
);
  logic [1:0] age;
  logic       rf_on;
  assign rf_on = rst_filt_en & ~lp_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;

  AST_BYPASS_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !lp_filt_en && !rst_filt_en) |-> rst_req == !$past(pin_n, 2)); // R2

  AST_LPMODE_SKIPS_RF: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && !lp_filt_en && lp_mode) |-> rst_req == !$past(pin_n, 2)); // R6

  AST_LP_ACCEPT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && lp_filt_en && $past(lp_filt_en) && lp_q != $past(lp_q))
      |-> $past(lp_cnt) == LPW'(LP_CYCLES - 1)); // R3

  AST_RF_ACCEPT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && rf_on && $past(rf_on) && rst_req != $past(rst_req))
      |-> $past(rf_cnt) == $past(filt_width)); // R4

  AST_RF_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && rf_on && $past(rf_on) && rf_cnt != '0)
      |-> rf_cnt == $past(rf_cnt) + WIDTH_BITS'(1)); // R5
endmodule

bind rst_pin_filter rst_pin_filter_chk #(
  .WIDTH_BITS(WIDTH_BITS), .LP_CYCLES(LP_CYCLES), .LPW(LPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .lp_mode(lp_mode),
  .lp_filt_en(lp_filt_en), .rst_filt_en(rst_filt_en), .filt_width(filt_width),
  .rst_req(rst_req), .lp_q(lp_q), .lp_cnt(lp_cnt), .rf_cnt(rf_cnt)
);

// File: tb/test_rst_pin_filter.sv
`timescale 1ns/1ps
module test_rst_pin_filter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       lp_mode = 1'b0;
  logic       lp_filt_en = 1'b0;
  logic       rst_filt_en = 1'b0;
  logic [7:0] filt_width = 8'd0;
  logic       rst_req;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;
  exp_t sb[$];
  exp_t it;

  rst_pin_filter i_rst_pin_filter (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .lp_mode(lp_mode),
    .lp_filt_en(lp_filt_en), .rst_filt_en(rst_filt_en),
    .filt_width(filt_width), .rst_req(rst_req)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      total++;
      if (it.at != cyc || rst_req !== it.val) begin
        bad++;
        $display("FAIL %s cycle %0d: rst_req=%b expected %b", it.tag, cyc, rst_req, it.val);
      end
    end
  end

  task automatic push(input int at, input logic val, input string tag);
    exp_t e;
    e.at = at; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic direct(input logic exp, input string tag);
    total++;
    if (rst_req !== exp) begin
      bad++;
      $display("FAIL %s: rst_req=%b expected %b", tag, rst_req, exp);
    end
  endtask

  task automatic cfg(input logic lpe, input logic rfe, input logic [7:0] w, input logic lpm);
    lp_filt_en = lpe; rst_filt_en = rfe; filt_width = w; lp_mode = lpm;
    repeat (3) @(negedge clk);
  endtask

  task automatic step(input logic lvl, input int lat, input string tag);
    push(cyc + lat - 1, !pin_n, tag);
    push(cyc + lat, !lvl, tag);
    pin_n = lvl;
    repeat (lat + 4) @(negedge clk);
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    pin_n = 1'b0;
    repeat (4) @(negedge clk);
    direct(1'b0, "R1 held in reset with pin low");
    pin_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    direct(1'b0, "R1 first cycle after reset");
    repeat (2) @(negedge clk);
    direct(1'b0, "R1 idle after reset");

    cfg(1'b0, 1'b0, 8'd0, 1'b0);
    step(1'b0, 2, "R2 assert unfiltered");
    step(1'b1, 2, "R2 release unfiltered");

    cfg(1'b1, 1'b0, 8'd0, 1'b0);
    step(1'b0, 5, "R3 assert fixed qualifier");
    step(1'b1, 5, "R3 release fixed qualifier");
    c = cyc;
    for (int k = 1; k <= 9; k++) push(c + k, 1'b0, "R3 two-cycle pulse rejected");
    pin_n = 1'b0; repeat (2) @(negedge clk); pin_n = 1'b1;
    repeat (10) @(negedge clk);
    c = cyc;
    push(c + 4, 1'b0, "R3 three-cycle pulse");
    push(c + 5, 1'b1, "R3 three-cycle pulse");
    push(c + 7, 1'b1, "R3 three-cycle pulse");
    push(c + 8, 1'b0, "R3 three-cycle pulse");
    pin_n = 1'b0; repeat (3) @(negedge clk); pin_n = 1'b1;
    repeat (10) @(negedge clk);

    cfg(1'b0, 1'b1, 8'd4, 1'b0);
    step(1'b0, 7, "R4 assert width 4");
    step(1'b1, 7, "R4 release width 4");
    c = cyc;
    for (int k = 1; k <= 10; k++) push(c + k, 1'b0, "R5 bounce restarts count");
    push(c + 11, 1'b1, "R5 bounce restarts count");
    pin_n = 1'b0; repeat (3) @(negedge clk);
    pin_n = 1'b1; @(negedge clk);
    pin_n = 1'b0; repeat (10) @(negedge clk);
    step(1'b1, 7, "R5 release after bounce");

    cfg(1'b0, 1'b1, 8'd0, 1'b0);
    step(1'b0, 3, "R4 width 0");
    step(1'b1, 3, "R4 width 0 release");
    cfg(1'b0, 1'b1, 8'd255, 1'b0);
    step(1'b0, 258, "R4 width 255");
    step(1'b1, 258, "R4 width 255 release");

    cfg(1'b0, 1'b1, 8'd4, 1'b1);
    step(1'b0, 2, "R6 low-power bypass");
    step(1'b1, 2, "R6 low-power bypass release");

    cfg(1'b1, 1'b1, 8'd4, 1'b1);
    step(1'b0, 5, "R7 fixed qualifier in low-power mode");
    step(1'b1, 5, "R7 release in low-power mode");

    cfg(1'b1, 1'b1, 8'd2, 1'b0);
    step(1'b0, 8, "R8 series assert");
    step(1'b1, 8, "R8 series release");

    repeat (5) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done == 1'b1);
      begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule